// File: doc/BRIEF.md
# Reloading Interval Timer with Overrun Detection

This block produces a periodic event that software can use as a time base. A free-running prescaler cuts the core clock down by 64, or by 2 when a test-mode pin is high. Each prescaler tick steps an 8-bit down counter. The counter reloads from a programmable interval register. Each time the count runs out, an elapsed flag is raised. If the previous elapsed event was never acknowledged, a separate overrun flag is raised as well.

Software opens the interval register by setting a load flag. While that flag is up, writes land in the register. Dropping the flag copies the register into the counter, so the new period starts from a known point. The counter never stops, including while the load flag is up. The interrupt output is the elapsed flag gated by an enable pin.

Every pin is a plain control or status pin. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `tick_interval_timer`

## Requirements
- R1: `ld_set` raises the load flag and `ld_clr` lowers it. If both are high in the same cycle, `ld_set` wins. A write strobe `ivl_wr` stores `ivl_wdata` into the interval register only while the load flag is up. A write made while the flag is down is ignored.
- R2: One cycle after the load flag falls, the interval register is copied into the down counter. That reload takes priority over a prescaler tick in the same cycle, and it restarts the period.
- R3: The prescaler emits one tick every 64 clocks when `test_mode` is 0, and one tick every 2 clocks when `test_mode` is 1. No two ticks are ever adjacent.
- R4: An interval value N from 1 to 255 gives one expiry every N ticks in steady state. At each expiry, `elapsed` is set and the counter reloads from the interval register.
- R5: An interval value of 0 behaves the same as 1, giving one expiry per tick.
- R6: An expiry that occurs while `elapsed` is still set, and is not being cleared in that cycle, sets `overrun`.
- R7: `elapsed_clr` clears `elapsed` but leaves `overrun` unchanged. Only `overrun_clr` or reset clears `overrun`. A set and a clear in the same cycle leave the flag set.
- R8: `irq` is high exactly when `elapsed` and `irq_en` are both high.
- R9: After reset, `elapsed`, `overrun`, `irq` and `ld_flag` are 0, and the interval register and the counter hold 0xFF.
- R10: The timer keeps counting and expiring while the load flag is up. There is no stop control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_set | input | 1 | Raise the load flag |
| ld_clr | input | 1 | Lower the load flag; the counter reload follows |
| ivl_wr | input | 1 | Interval register write strobe |
| ivl_wdata | input | 8 | Interval value to store |
| test_mode | input | 1 | 1 selects the divide-by-2 prescaler |
| elapsed_clr | input | 1 | Acknowledge the elapsed flag |
| overrun_clr | input | 1 | Clear the overrun flag |
| irq_en | input | 1 | Interrupt enable |
| ld_flag | output | 1 | Current state of the load flag |
| elapsed | output | 1 | Elapsed flag |
| overrun | output | 1 | Overrun flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench measures the steady-state period between expiries at interval values 1, 3 and 255 in test mode, at value 2 in normal mode, and at value 0. A divider off by one, or a counter that reloads one step late, would show up as a period of N+1 ticks. It also checks that a write made with the load flag down does not change the period, and that dropping the flag restarts the count immediately. A design that reloaded only at the next expiry would leave a long old period running. Finally, it confirms that acknowledging `elapsed` leaves `overrun` standing, and that expiries continue while the load flag is up. A design that paused the counter during programming would never set `elapsed` in that window.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned TMR_W_DEF    = 8;
  localparam int unsigned TMR_NDIV_DEF = 64;
  localparam int unsigned TMR_TDIV_DEF = 2;

  typedef struct packed {
    logic elapsed;
    logic overrun;
  } tmr_flags_t;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int unsigned NORM_DIV = 64,
  parameter int unsigned TEST_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic test_mode,
  output logic tick
);
  localparam int unsigned MAXDIV = (NORM_DIV > TEST_DIV) ? NORM_DIV : TEST_DIV;
  localparam int unsigned PW     = (MAXDIV > 2) ? $clog2(MAXDIV) : 1;
  localparam logic [PW-1:0] NLIM = PW'(NORM_DIV - 1);
  localparam logic [PW-1:0] TLIM = PW'(TEST_DIV - 1);

  logic [PW-1:0] pcnt;
  logic [PW-1:0] lim;

  always_comb begin
    lim  = test_mode ? TLIM : NLIM;
    tick = (pcnt >= lim);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pcnt <= '0;
    else if (tick) pcnt <= '0;
    else           pcnt <= pcnt + 1'b1;
  end

  // R3: ticks are never back to back
  assert_no_double_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/tmr_load_ctl.sv
module tmr_load_ctl #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_set,
  input  logic         ld_clr,
  input  logic         ivl_wr,
  input  logic [W-1:0] ivl_wdata,
  output logic         ld_flag,
  output logic [W-1:0] ivl_q,
  output logic         reload
);
  logic ld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ld_q <= 1'b0;
    else if (ld_set) ld_q <= 1'b1;
    else if (ld_clr) ld_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              ivl_q <= '1;
    else if (ivl_wr && ld_q) ivl_q <= ivl_wdata;
  end

  // registered reload pulse: fires the cycle after the flag drops
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reload <= 1'b0;
    else        reload <= ld_q && ld_clr && !ld_set;
  end

  assign ld_flag = ld_q;

  // R1: interval register frozen while the load flag is down
  assert_ignore_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_q |=> $stable(ivl_q));
endmodule

// File: rtl/tmr_downcount.sv
module tmr_downcount #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         reload,
  input  logic         ld_flag,
  input  logic [W-1:0] ivl_q,
  output logic         expire
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt;

  always_comb expire = tick && !reload && (cnt <= ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '1;
    else if (reload) cnt <= ivl_q;
    else if (tick) begin
      if (cnt <= ONE) cnt <= ivl_q;
      else            cnt <= cnt - 1'b1;
    end
  end

  // R2: counter restarts from the interval register after the flag falls
  assert_reload_on_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ld_flag) |=> (cnt == $past(ivl_q)));
  // R4: the count only moves on a tick or a reload
  assert_step_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !reload) |=> $stable(cnt));
endmodule

// File: rtl/tmr_flags.sv
module tmr_flags
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       expire,
  input  logic       elapsed_clr,
  input  logic       overrun_clr,
  output tmr_flags_t flags
);
  tmr_flags_t fq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fq <= '0;
    end else begin
      if (expire)           fq.elapsed <= 1'b1;
      else if (elapsed_clr) fq.elapsed <= 1'b0;

      if (expire && fq.elapsed && !elapsed_clr) fq.overrun <= 1'b1;
      else if (overrun_clr)                     fq.overrun <= 1'b0;
    end
  end

  assign flags = fq;

  // R4: every expiry leaves elapsed set
  assert_elapsed_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> fq.elapsed);
  // R6: unacknowledged expiry raises overrun
  assert_overrun_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && fq.elapsed && !elapsed_clr) |=> fq.overrun);
  // R7: overrun holds until its own clear
  assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fq.overrun && !overrun_clr) |=> fq.overrun);
endmodule

// File: rtl/tick_interval_timer.sv
module tick_interval_timer
  import tmr_pkg::*;
#(
  parameter int unsigned W        = TMR_W_DEF,
  parameter int unsigned NORM_DIV = TMR_NDIV_DEF,
  parameter int unsigned TEST_DIV = TMR_TDIV_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_set,
  input  logic         ld_clr,
  input  logic         ivl_wr,
  input  logic [W-1:0] ivl_wdata,
  input  logic         test_mode,
  input  logic         elapsed_clr,
  input  logic         overrun_clr,
  input  logic         irq_en,
  output logic         ld_flag,
  output logic         elapsed,
  output logic         overrun,
  output logic         irq
);
  logic         tick;
  logic         reload;
  logic         expire;
  logic [W-1:0] ivl_q;
  tmr_flags_t   flags;

  tmr_prescale #(.NORM_DIV(NORM_DIV), .TEST_DIV(TEST_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .tick(tick));

  tmr_load_ctl #(.W(W)) u_ld (
    .clk(clk), .rst_n(rst_n), .ld_set(ld_set), .ld_clr(ld_clr),
    .ivl_wr(ivl_wr), .ivl_wdata(ivl_wdata), .ld_flag(ld_flag),
    .ivl_q(ivl_q), .reload(reload));

  tmr_downcount #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reload(reload),
    .ld_flag(ld_flag), .ivl_q(ivl_q), .expire(expire));

  tmr_flags u_flg (
    .clk(clk), .rst_n(rst_n), .expire(expire), .elapsed_clr(elapsed_clr),
    .overrun_clr(overrun_clr), .flags(flags));

  assign elapsed = flags.elapsed;
  assign overrun = flags.overrun;
  assign irq     = flags.elapsed & irq_en;

  // R8: no interrupt while disabled
  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);
endmodule

// File: tb/sim_tick_interval_timer.sv
`timescale 1ns/1ps
module sim_tick_interval_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ld_set = 0, ld_clr = 0, ivl_wr = 0;
  logic [7:0] ivl_wdata = 0;
  logic       test_mode = 1, elapsed_clr = 0, overrun_clr = 0, irq_en = 0;
  logic       ld_flag, elapsed, overrun, irq;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tick_interval_timer u0 (
    .clk(clk), .rst_n(rst_n), .ld_set(ld_set), .ld_clr(ld_clr),
    .ivl_wr(ivl_wr), .ivl_wdata(ivl_wdata), .test_mode(test_mode),
    .elapsed_clr(elapsed_clr), .overrun_clr(overrun_clr), .irq_en(irq_en),
    .ld_flag(ld_flag), .elapsed(elapsed), .overrun(overrun), .irq(irq));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_eclr();
    elapsed_clr = 1; @(negedge clk); elapsed_clr = 0;
  endtask

  task automatic pulse_oclr();
    overrun_clr = 1; @(negedge clk); overrun_clr = 0;
  endtask

  // raise flag, write value, drop flag
  task automatic program_ivl(input logic [7:0] v);
    ld_set = 1; @(negedge clk); ld_set = 0;
    ivl_wr = 1; ivl_wdata = v; @(negedge clk); ivl_wr = 0;
    ld_clr = 1; @(negedge clk); ld_clr = 0;
  endtask

  task automatic wait_el(input int lim, output int t, output bit ok);
    ok = 0; t = 0;
    for (int i = 0; i < lim; i++) begin
      if (elapsed) begin ok = 1; t = cyc; break; end
      @(negedge clk);
    end
  endtask

  task automatic measure(input int lim, output int p);
    int t0, t1; bit ok0, ok1;
    wait_el(lim, t0, ok0); pulse_eclr();
    wait_el(lim, t0, ok0); pulse_eclr();
    wait_el(lim, t1, ok1);
    p = (ok0 && ok1) ? (t1 - t0) : -1;
  endtask

  task automatic t_reset();
    chk(elapsed == 0, "R9 elapsed", elapsed, 0);
    chk(overrun == 0, "R9 overrun", overrun, 0);
    chk(irq == 0, "R9 irq", irq, 0);
    chk(ld_flag == 0, "R9 ld_flag", ld_flag, 0);
  endtask

  task automatic t_period(input logic tm, input logic [7:0] n, input int exp, input string req);
    int p;
    test_mode = tm;
    program_ivl(n);
    measure(exp * 4 + 20, p);
    chk(p == exp, req, p, exp);
  endtask

  task automatic t_ignored_write();
    int p;
    test_mode = 1;
    program_ivl(8'd3);
    ivl_wr = 1; ivl_wdata = 8'd9; @(negedge clk); ivl_wr = 0;
    ld_set = 1; @(negedge clk); ld_set = 0;
    ld_clr = 1; @(negedge clk); ld_clr = 0;
    measure(100, p);
    chk(p == 6, "R1 write with flag down ignored", p, 6);
  endtask

  task automatic t_reload_restart();
    int t; bit ok; int t0;
    test_mode = 1;
    program_ivl(8'd255);
    pulse_eclr();
    repeat (10) @(negedge clk);
    pulse_eclr();
    ld_set = 1; @(negedge clk); ld_set = 0;
    ivl_wr = 1; ivl_wdata = 8'd2; @(negedge clk); ivl_wr = 0;
    pulse_eclr();
    ld_clr = 1; @(negedge clk); ld_clr = 0;
    t0 = cyc;
    wait_el(12, t, ok);
    chk(ok, "R2 restart after flag drop", ok, 1);
  endtask

  task automatic t_runs_while_loading();
    int t; bit ok;
    test_mode = 1;
    program_ivl(8'd2);
    ld_set = 1; @(negedge clk); ld_set = 0;
    pulse_eclr();
    wait_el(20, t, ok);
    chk(ok && ld_flag, "R10 expiry while flag up", ok, 1);
    ld_clr = 1; @(negedge clk); ld_clr = 0;
    chk(ld_flag == 0, "R1 flag lowered", ld_flag, 0);
  endtask

  task automatic t_overrun();
    int t; bit ok;
    test_mode = 1;
    program_ivl(8'd2);
    pulse_eclr(); pulse_oclr();
    wait_el(20, t, ok);
    chk(overrun == 0, "R6 no overrun after ack", overrun, 0);
    repeat (5) @(negedge clk);
    chk(overrun == 1, "R6 overrun on second expiry", overrun, 1);
    chk(elapsed == 1, "R6 elapsed held", elapsed, 1);
    program_ivl(8'd255);
    pulse_eclr();
    chk(elapsed == 0, "R7 elapsed cleared", elapsed, 0);
    chk(overrun == 1, "R7 overrun kept", overrun, 1);
    pulse_oclr();
    chk(overrun == 0, "R7 overrun cleared", overrun, 0);
  endtask

  task automatic t_irq();
    int t; bit ok;
    test_mode = 1;
    program_ivl(8'd255);
    wait_el(700, t, ok);
    irq_en = 0; #1;
    chk(irq == 0, "R8 irq masked", irq, 0);
    irq_en = 1; #1;
    chk(irq == 1, "R8 irq enabled", irq, 1);
    @(negedge clk);
    pulse_eclr(); #1;
    chk(irq == 0, "R8 irq follows elapsed", irq, 0);
    irq_en = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_period(1, 8'd3, 6, "R4 period N=3 test");
    t_period(1, 8'd1, 2, "R4 period N=1 test");
    t_period(1, 8'd0, 2, "R5 zero acts as one");
    t_period(1, 8'd255, 510, "R4 period N=255 test");
    t_period(0, 8'd2, 128, "R3 normal divide by 64");
    t_ignored_write();
    t_reload_restart();
    t_runs_while_loading();
    t_overrun();
    t_irq();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule